// File: doc/BRIEF.md
# Two-Button Sequence Lock with Attempt Lockout

This block turns presses on two push-button strobes into a serial bit stream. One strobe enters a 0 and the other enters a 1. A finite-state recognizer watches that stream for the pattern 1101. Overlapping occurrences count, so 1101101 holds two matches. An attempt counter allows eight presses to reach a match. If eight presses pass with no success, the block locks and ignores every further press until the external reset.

The strobes are taken as already debounced, synchronized and one clock cycle wide. A cycle in which both strobes are high is discarded. It is neither decoded nor counted.

Once a match has been seen, the attempt counter freezes, so the block can no longer lock. The recognizer keeps accepting presses and flags any later matches.

The recognizer has four states:
- `REC_IDLE`: no progress.
- `REC_GOT1`: the last bit was 1.
- `REC_GOT11`: the last bits were 11.
- `REC_GOT110`: the last bits were 110.

Its transitions on an accepted bit are:

| From | On 0 | On 1 |
|---|---|---|
| `REC_IDLE` | stays in `REC_IDLE` | `REC_GOT1` |
| `REC_GOT1` | `REC_IDLE` | `REC_GOT11` |
| `REC_GOT11` | `REC_GOT110` | stays in `REC_GOT11` |
| `REC_GOT110` | `REC_IDLE` | `REC_GOT1`, and this transition is the match |

The lock controller has three phases:
- `PH_ARMED` counts accepted presses. It goes to `PH_SOLVED` on a match. On the eighth press without a match it goes to `PH_LOCKED`, and a match wins when both happen on the same press.
- `PH_SOLVED` holds until reset.
- `PH_LOCKED` holds until reset.

Reset sends the recognizer to `REC_IDLE` and the lock controller to `PH_ARMED` with a zero count.

Top module: `seq_lock_top`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the next cycle shows `match_o`=0 and `locked_o`=0. The recognizer returns to idle and the attempt count to zero.
- R2: A press on `press_one` alone enters bit 1, and a press on `press_zero` alone enters bit 0. When the last four entered bits are 1,1,0,1, `match_o` is 1 for exactly the one cycle after the edge that sampled the completing press.
- R3: Any entered sequence whose last four bits are not 1,1,0,1 leaves `match_o` at 0. This includes 1011 and streams with partial prefixes that restart.
- R4: Matches overlap. After 1101, the further bits 101 produce a second match.
- R5: A cycle with both strobes high is ignored. It changes neither the recognizer progress nor the attempt count.
- R6: After the eighth accepted press with no match since reset, `locked_o` is 1 from the cycle after that press's edge.
- R7: While `locked_o` is 1, presses are ignored. No sequence produces `match_o`, and `locked_o` stays 1.
- R8: After a match, the attempt count no longer advances. Any number of further presses never sets `locked_o`, and later matches are still flagged.
- R9: A match completed by the eighth press sets `match_o` and does not lock.
- R10: Only reset clears `locked_o`. After reset, a fresh eight presses are allowed.
- R11: Cycles with neither strobe high change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| press_zero | input | 1 | One-cycle strobe entering bit 0 |
| press_one | input | 1 | One-cycle strobe entering bit 1 |
| match_o | output | 1 | One-cycle pulse after a press that completes 1101 |
| locked_o | output | 1 | High while input is shut off after eight failed presses |

## Verification
Two functions can coincide on one press: the press that completes 1101 can also be the eighth counted press. The bench provokes this by entering 0,0,0,0,1,1,0,1 after reset. It judges that `match_o` pulses, `locked_o` stays 0, and a long run of further presses still never locks. The second collision is both strobes in one cycle. The bench inserts such a cycle inside a pattern, and again just before the eighth press, and expects the match and the lock to arrive exactly as if that cycle were absent.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

    typedef enum logic [1:0] {
        REC_IDLE   = 2'd0,
        REC_GOT1   = 2'd1,
        REC_GOT11  = 2'd2,
        REC_GOT110 = 2'd3
    } rec_state_t;

    typedef enum logic [1:0] {
        PH_ARMED  = 2'd0,
        PH_SOLVED = 2'd1,
        PH_LOCKED = 2'd2
    } lock_phase_t;

endpackage

// File: rtl/press_decoder.sv
module press_decoder (
    input  logic press_zero,
    input  logic press_one,
    input  logic enable,
    output logic take,
    output logic bit_val
);
    logic single;

    always_comb begin
        single  = press_zero ^ press_one;
        take    = single & enable;
        bit_val = press_one;
    end
endmodule

// File: rtl/seq_recognizer.sv
module seq_recognizer
    import seq_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic bit_val,
    output logic hit,
    output logic match_q
);
    rec_state_t state_q, state_d;

    // next state and completion detection
    always_comb begin
        state_d = state_q;
        hit     = 1'b0;
        if (take) begin
            unique case (state_q)
                REC_IDLE:   state_d = bit_val ? REC_GOT1  : REC_IDLE;
                REC_GOT1:   state_d = bit_val ? REC_GOT11 : REC_IDLE;
                REC_GOT11:  state_d = bit_val ? REC_GOT11 : REC_GOT110;
                REC_GOT110: begin
                    state_d = bit_val ? REC_GOT1 : REC_IDLE;
                    hit     = bit_val;
                end
                default:    state_d = REC_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= REC_IDLE;
        else     state_q <= state_d;
    end

    // registered output
    always_ff @(posedge clk) begin
        if (rst) match_q <= 1'b0;
        else     match_q <= hit;
    end
endmodule

// File: rtl/lock_controller.sv
module lock_controller
    import seq_lock_pkg::*;
#(
    parameter int ATTEMPTS = 8,
    parameter int CNT_W    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic hit,
    output logic enable,
    output logic locked
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ATTEMPTS - 1);

    lock_phase_t      phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_ARMED: begin
                if (take) begin
                    cnt_d = cnt_q + 1'b1;
                    if (hit)                   phase_d = PH_SOLVED;
                    else if (cnt_q == LAST_IDX) phase_d = PH_LOCKED;
                end
            end
            PH_SOLVED: phase_d = PH_SOLVED;
            PH_LOCKED: phase_d = PH_LOCKED;
            default:   phase_d = PH_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ARMED;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        locked = (phase_q == PH_LOCKED);
        enable = !locked;
    end
endmodule

// File: rtl/seq_lock_top.sv
module seq_lock_top #(
    parameter int ATTEMPTS = 8,
    parameter int CNT_W    = $clog2(ATTEMPTS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic press_zero,
    input  logic press_one,
    output logic match_o,
    output logic locked_o
);
    logic take, bit_val, hit, enable;

    press_decoder u_dec (
        .press_zero (press_zero),
        .press_one  (press_one),
        .enable     (enable),
        .take       (take),
        .bit_val    (bit_val)
    );

    seq_recognizer u_rec (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .bit_val (bit_val),
        .hit     (hit),
        .match_q (match_o)
    );

    lock_controller #(
        .ATTEMPTS (ATTEMPTS),
        .CNT_W    (CNT_W)
    ) u_lock (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .hit    (hit),
        .enable (enable),
        .locked (locked_o)
    );
endmodule

// File: rtl/seq_lock_checker.sv
module seq_lock_checker (
    input logic clk,
    input logic rst,
    input logic press_zero,
    input logic press_one,
    input logic match_o,
    input logic locked_o
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!match_o && !locked_o));

    // R2: a match is a single-cycle pulse following a lone one-press
    a_r2_match_pulse: assert property (@(posedge clk) disable iff (rst)
        match_o |=> !match_o);
    a_r2_match_after_one: assert property (@(posedge clk) disable iff (rst)
        match_o |-> $past(press_one && !press_zero));

    // R5
    a_r5_both_ignored: assert property (@(posedge clk) disable iff (rst)
        (press_zero && press_one) |=> !match_o);

    // R6: lock appears only right after a lone press
    a_r6_lock_on_press: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(press_zero ^ press_one));

    // R7 and R10
    a_r7_locked_sticky: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> locked_o);
    a_r7_no_match_locked: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> !match_o);

    // R8
    a_r8_match_not_locked: assert property (@(posedge clk) disable iff (rst)
        match_o |-> !locked_o);

    // R11
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!press_zero && !press_one) |=> (!match_o && $stable(locked_o)));
endmodule

bind seq_lock_top seq_lock_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .press_zero (press_zero),
    .press_one  (press_one),
    .match_o    (match_o),
    .locked_o   (locked_o)
);

// File: tb/tb_seq_lock_top.sv
module tb_seq_lock_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic press_zero = 1'b0;
    logic press_one  = 1'b0;
    logic match_o, locked_o;

    always #2 clk = ~clk;

    seq_lock_top dut (
        .clk        (clk),
        .rst        (rst),
        .press_zero (press_zero),
        .press_one  (press_one),
        .match_o    (match_o),
        .locked_o   (locked_o)
    );

    typedef struct {
        logic  m;
        logic  l;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    logic [2:0] hist = '0;
    int nbits = 0;
    int cnt   = 0;
    bit solved = 0;
    bit locked = 0;

    // driver: one cycle of stimulus, expectation pushed for after the edge
    task automatic step(input bit z, input bit o, input bit r, input string tag);
        exp_t e;
        bit acc, m;
        @(negedge clk);
        press_zero = z;
        press_one  = o;
        rst        = r;
        m = 1'b0;
        if (r) begin
            hist = '0; nbits = 0; cnt = 0; solved = 0; locked = 0;
        end else begin
            acc = (z ^ o) && !locked;
            if (acc) begin
                m = (nbits >= 3) && ({hist, o} == 4'b1101);
                hist  = {hist[1:0], o};
                if (nbits < 4) nbits++;
                if (!solved) begin
                    cnt++;
                    if (m) solved = 1;
                    else if (cnt == 8) locked = 1;
                end
            end
        end
        e.m = m; e.l = locked; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic enter(input bit b, input string tag);
        step(!b, b, 0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, tag);
    endtask

    task automatic do_reset(input string tag);
        step(0, 0, 1, tag);
        step(0, 0, 1, tag);
    endtask

    // monitor: compare after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (match_o !== e.m || locked_o !== e.l) begin
                errors++;
                $display("FAIL %s: match=%b locked=%b expected match=%b locked=%b",
                         e.tag, match_o, locked_o, e.m, e.l);
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset("R1");
        // R11 idle cycles
        idle(5, "R11");
        // R2 basic match
        enter(1, "R2"); enter(1, "R2"); enter(0, "R2"); enter(1, "R2");
        idle(3, "R2");
        // R3 non-matching sequences
        do_reset("R1");
        enter(1, "R3"); enter(0, "R3"); enter(1, "R3"); enter(1, "R3");
        enter(1, "R3"); enter(0, "R3"); enter(0, "R3");
        do_reset("R1");
        // R4 overlapping matches
        enter(1, "R4"); enter(1, "R4"); enter(0, "R4"); enter(1, "R4");
        enter(1, "R4"); enter(0, "R4"); enter(1, "R4");
        idle(2, "R4");
        // R5 both strobes inside a pattern
        do_reset("R1");
        enter(1, "R5"); enter(1, "R5"); enter(0, "R5");
        step(1, 1, 0, "R5");
        enter(1, "R5");
        // R5 both strobes do not count an attempt
        do_reset("R1");
        for (int i = 0; i < 7; i++) enter(0, "R5");
        step(1, 1, 0, "R5");
        idle(1, "R5");
        // R6 eighth failed press locks
        enter(0, "R6");
        idle(2, "R6");
        // R7 presses ignored while locked
        enter(1, "R7"); enter(1, "R7"); enter(0, "R7"); enter(1, "R7");
        idle(3, "R7");
        // R10 only reset clears, fresh eight allowed
        do_reset("R10");
        for (int i = 0; i < 7; i++) enter(1, "R10");
        idle(1, "R10");
        enter(1, "R10");
        idle(1, "R10");
        // R8 match freezes counter
        do_reset("R1");
        enter(1, "R8"); enter(1, "R8"); enter(0, "R8"); enter(1, "R8");
        for (int i = 0; i < 20; i++) enter(0, "R8");
        enter(1, "R8"); enter(1, "R8"); enter(0, "R8"); enter(1, "R8");
        idle(2, "R8");
        // R9 match on the eighth press
        do_reset("R1");
        enter(0, "R9"); enter(0, "R9"); enter(0, "R9"); enter(0, "R9");
        enter(1, "R9"); enter(1, "R9"); enter(0, "R9"); enter(1, "R9");
        for (int i = 0; i < 12; i++) enter(0, "R9");
        idle(3, "R11");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule